// File: doc/BRIEF.md
# I2C SCL Clock Period Generator

This block times the SCL waveform of an I2C controller acting as bus master. A divider count sets the length of one timing unit in enabled ticks of the system clock. The block pulls SCL low for a low phase, releases it, waits until the sampled line is seen high, and then counts a high phase before pulling low again. Three timing rules are available. Standard mode uses equal low and high phases. Fast and fast-plus modes use an unequal low/high ratio, picked by a duty select: either 2:1 or 16:9.

A rise-time count is taken off the counted high phase. This accounts for the time the line spends rising after release. Because the high count starts only when the line reads high, a slave that holds SCL low stretches the period without any help from the block. The mode, duty, divider and rise-time inputs are captured at the start of each low phase, so a full period always runs on one consistent setting. Start and stop sequencing, the data shifter and the register interface live elsewhere. They use the two phase strobes to place their own events.

Top module: `scl_period_gen`

## Requirements
- R1: With modeSel = 2'b00 (standard), the low phase lasts D enabled ticks and the counted high phase lasts D ticks, where D is the effective divider.
- R2: With modeSel nonzero (2'b01 fast, 2'b10 or 2'b11 fast-plus, all using fast rules) and dutySel = 0, the low phase lasts 2·D ticks and the counted high phase lasts D ticks.
- R3: With fast rules and dutySel = 1, the low phase lasts 16·D ticks and the counted high phase lasts 9·D ticks.
- R4: In standard mode, a divCount below 4 gives an effective divider D = 4. Otherwise D = divCount.
- R5: Under fast rules, a divCount of 0 gives D = 1. Otherwise D = divCount.
- R6: The counted high phase lasts max(1, H − riseCount) ticks, where H is the nominal high length from R1 to R3. riseCount is a 7-bit value up to 127.
- R7: After the low phase ends, SCL is released, and the high count starts only on a tick where sclIn reads 1. With an immediately rising line this wait is exactly one tick. Each further tick that sclIn is held low lengthens the period by one tick.
- R8: While runEn is 0, sclDriveLow is 0 and no strobe fires. Counting is cleared, so after runEn returns to 1 the next low phase has its full length.
- R9: modeSel, dutySel, divCount and riseCount are captured only when a low phase begins. A change made during a period has no effect until the next low phase.
- R10: Counters and phase changes advance only on cycles where tickEn is 1. With tickEn high every other cycle, every phase lasts twice as many clock cycles.
- R11: lowStart is high for exactly the first clock cycle in which sclDriveLow is 1. highStart is high for exactly the first cycle of the counted high phase. The two are never high together. The first low phase begins on the first tick edge after runEn rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | Clock enable for all counting |
| runEn | input | 1 | Block enable; when low, SCL is released and counting is cleared |
| modeSel | input | 2 | 00 standard, 01 fast, 1x fast-plus (fast rules) |
| dutySel | input | 1 | Fast-rule ratio: 0 gives 2:1 low/high, 1 gives 16:9 |
| divCount | input | DIV_W | Divider count (timing unit in ticks) |
| riseCount | input | RISE_W | Rise-time compensation taken from the high phase |
| sclIn | input | 1 | Sampled SCL line level |
| sclDriveLow | output | 1 | Request to pull SCL low |
| highStart | output | 1 | One-cycle strobe at the start of the counted high phase |
| lowStart | output | 1 | One-cycle strobe at the start of the low phase |

## Verification
A wrong phase register or a bad counter shows at the ports within a single SCL period. It appears as a low or high phase of the wrong length, a strobe in the wrong cycle, or a missing release after the low phase. A wrong captured setting shows up in the very next low phase, since its length is counted directly from the captured divider and ratio. A wrong clamp or rise subtraction changes the measured tick counts by a known amount in one period. Each scenario therefore measures whole periods edge by edge, including the periods on either side of a setting change, a disable and a stretched high.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCfg;  // capture settings for a new period
    logic clrCnt;   // zero the phase counter
    logic incCnt;   // advance the phase counter
  } ctrlStrb_t;

  localparam int STD_MIN_DIV  = 4;
  localparam int FAST_MIN_DIV = 1;

endpackage

// File: rtl/scl_gen_datapath.sv
module scl_gen_datapath
  import scl_gen_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int RISE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              dutySel,
  input  logic [DIV_W-1:0]  divCount,
  input  logic [RISE_W-1:0] riseCount,
  input  ctrlStrb_t         strb,
  output logic              lowLast,
  output logic              highLast
);

  localparam int LEN_W = DIV_W + 5;

  logic              fastQ;
  logic              dutyQ;
  logic [DIV_W-1:0]  divQ;
  logic [RISE_W-1:0] riseQ;
  logic [LEN_W-1:0]  cnt;

  logic [DIV_W-1:0]  divClamped;
  logic              fastIn;
  logic [LEN_W-1:0]  divExt;
  logic [LEN_W-1:0]  riseExt;
  logic [LEN_W-1:0]  lowLen;
  logic [LEN_W-1:0]  highLen;
  logic [LEN_W-1:0]  highCnt;

  // Per-mode minimum divider
  always_comb begin
    fastIn     = |modeSel;
    divClamped = divCount;
    if (fastIn) begin
      if (divCount < DIV_W'(FAST_MIN_DIV)) divClamped = DIV_W'(FAST_MIN_DIV);
    end else begin
      if (divCount < DIV_W'(STD_MIN_DIV)) divClamped = DIV_W'(STD_MIN_DIV);
    end
  end

  // Settings captured only at the start of a low phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastQ <= 1'b0;
      dutyQ <= 1'b0;
      divQ  <= DIV_W'(STD_MIN_DIV);
      riseQ <= '0;
    end else if (strb.loadCfg) begin
      fastQ <= fastIn;
      dutyQ <= dutySel;
      divQ  <= divClamped;
      riseQ <= riseCount;
    end
  end

  // Phase lengths from the captured settings
  always_comb begin
    divExt  = LEN_W'(divQ);
    riseExt = LEN_W'(riseQ);
    if (!fastQ) begin
      lowLen  = divExt;
      highLen = divExt;
    end else if (dutyQ) begin
      lowLen  = divExt << 4;
      highLen = (divExt << 3) + divExt;
    end else begin
      lowLen  = divExt << 1;
      highLen = divExt;
    end
    if (riseExt >= highLen) highCnt = LEN_W'(1);
    else                    highCnt = highLen - riseExt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.clrCnt) cnt <= '0;
    else if (strb.incCnt) cnt <= cnt + LEN_W'(1);
  end

  assign lowLast  = (cnt == lowLen - LEN_W'(1));
  assign highLast = (cnt == highCnt - LEN_W'(1));

  AST_STD_LOW_MIN: assert property (@(posedge clk) disable iff (!rstN)
    !fastQ |-> lowLen >= LEN_W'(STD_MIN_DIV));  // R4

  AST_FAST_HIGH_MIN: assert property (@(posedge clk) disable iff (!rstN)
    fastQ |-> highCnt >= LEN_W'(1));  // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strb.incCnt |-> cnt != '1);  // R1

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadCfg |=> $stable(divQ) && $stable(fastQ) && $stable(dutyQ));  // R9

endmodule

// File: rtl/scl_gen_control.sv
module scl_gen_control
  import scl_gen_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tickEn,
  input  logic      runEn,
  input  logic      sclIn,
  input  logic      lowLast,
  input  logic      highLast,
  output ctrlStrb_t strb,
  output logic      sclDriveLow,
  output logic      lowStart,
  output logic      highStart
);

  phase_e phase;
  phase_e phaseNext;
  logic   enterLow;
  logic   enterHigh;

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    enterLow  = 1'b0;
    enterHigh = 1'b0;
    if (!runEn) begin
      phaseNext   = PH_IDLE;
      strb.clrCnt = 1'b1;
    end else if (tickEn) begin
      unique case (phase)
        PH_IDLE: begin
          phaseNext    = PH_LOW;
          strb.loadCfg = 1'b1;
          strb.clrCnt  = 1'b1;
          enterLow     = 1'b1;
        end
        PH_LOW: begin
          if (lowLast) begin
            phaseNext   = PH_WAIT;
            strb.clrCnt = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
        PH_WAIT: begin
          if (sclIn) begin
            phaseNext   = PH_HIGH;
            strb.clrCnt = 1'b1;
            enterHigh   = 1'b1;
          end
        end
        PH_HIGH: begin
          if (highLast) begin
            phaseNext    = PH_LOW;
            strb.loadCfg = 1'b1;
            strb.clrCnt  = 1'b1;
            enterLow     = 1'b1;
          end else begin
            strb.incCnt = 1'b1;
          end
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      lowStart  <= 1'b0;
      highStart <= 1'b0;
    end else begin
      phase     <= phaseNext;
      lowStart  <= enterLow;
      highStart <= enterHigh;
    end
  end

  assign sclDriveLow = (phase == PH_LOW);

  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !sclDriveLow && !lowStart && !highStart);  // R8

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(lowStart && highStart));  // R11

  AST_LOWSTART_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    lowStart |-> sclDriveLow);  // R11

  AST_HIGH_AFTER_LINE: assert property (@(posedge clk) disable iff (!rstN)
    highStart |-> $past(sclIn) && $past(tickEn));  // R7

  AST_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    highStart |-> !sclDriveLow);  // R7

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen
  import scl_gen_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int RISE_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              runEn,
  input  logic [1:0]        modeSel,
  input  logic              dutySel,
  input  logic [DIV_W-1:0]  divCount,
  input  logic [RISE_W-1:0] riseCount,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              highStart,
  output logic              lowStart
);

  ctrlStrb_t strb;
  logic      lowLast;
  logic      highLast;

  scl_gen_control uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .runEn      (runEn),
    .sclIn      (sclIn),
    .lowLast    (lowLast),
    .highLast   (highLast),
    .strb       (strb),
    .sclDriveLow(sclDriveLow),
    .lowStart   (lowStart),
    .highStart  (highStart)
  );

  scl_gen_datapath #(
    .DIV_W (DIV_W),
    .RISE_W(RISE_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .dutySel  (dutySel),
    .divCount (divCount),
    .riseCount(riseCount),
    .strb     (strb),
    .lowLast  (lowLast),
    .highLast (highLast)
  );

endmodule

// File: tb/tb_scl_period_gen.sv
module tb_scl_period_gen;

  localparam int DIV_W  = 12;
  localparam int RISE_W = 7;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b1;
  logic              runEn = 1'b0;
  logic [1:0]        modeSel = 2'b00;
  logic              dutySel = 1'b0;
  logic [DIV_W-1:0]  divCount = DIV_W'(5);
  logic [RISE_W-1:0] riseCount = '0;
  logic              stretch = 1'b0;
  logic              tickMode = 1'b0;
  logic              sclIn;
  logic              sclDriveLow;
  logic              highStart;
  logic              lowStart;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // Open-drain line model: low when driven or held by a slave
  assign sclIn = ~sclDriveLow & ~stretch;

  always @(negedge clk) begin
    if (tickMode) tickEn = ~tickEn;
    else          tickEn = 1'b1;
  end

  scl_period_gen #(.DIV_W(DIV_W), .RISE_W(RISE_W)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .runEn(runEn),
    .modeSel(modeSel), .dutySel(dutySel), .divCount(divCount),
    .riseCount(riseCount), .sclIn(sclIn), .sclDriveLow(sclDriveLow),
    .highStart(highStart), .lowStart(lowStart)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic syncLow();
    int guard = 0;
    @(negedge clk);
    while (!lowStart && guard < 3000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  // Starts at a negedge where lowStart is high; ends at the next one
  task automatic measureFrom(output int lowC, output int waitC, output int highC);
    int guard = 0;
    lowC = 0; waitC = 0; highC = 0;
    while (sclDriveLow && guard < 3000) begin
      lowC++; guard++;
      @(negedge clk);
    end
    while (!highStart && guard < 3000) begin
      waitC++; guard++;
      @(negedge clk);
    end
    do begin
      highC++; guard++;
      @(negedge clk);
    end while (!lowStart && guard < 3000);
  endtask

  task automatic expectPeriod(input string req, input int lowE, input int waitE, input int highE);
    int l, w, h;
    measureFrom(l, w, h);
    check(req, "low ticks", l, lowE);
    check(req, "wait ticks", w, waitE);
    check(req, "high ticks", h, highE);
  endtask

  task automatic setCfg(input logic [1:0] m, input logic d, input int dv, input int rs);
    modeSel   = m;
    dutySel   = d;
    divCount  = DIV_W'(dv);
    riseCount = RISE_W'(rs);
    syncLow();
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R8", "drive low at reset", int'(sclDriveLow), 0);
    check("R11", "lowStart at reset", int'(lowStart), 0);
    check("R11", "highStart at reset", int'(highStart), 0);
    runEn = 1'b1;
    @(negedge clk);
    check("R11", "lowStart after enable", int'(lowStart), 1);
    check("R11", "drive low after enable", int'(sclDriveLow), 1);
  endtask

  task automatic testStandard();
    setCfg(2'b00, 1'b0, 5, 0);
    expectPeriod("R1", 5, 1, 5);
    expectPeriod("R7", 5, 1, 5);
  endtask

  task automatic testFastTwo();
    setCfg(2'b01, 1'b0, 3, 0);
    expectPeriod("R2", 6, 1, 3);
  endtask

  task automatic testFastSixteen();
    setCfg(2'b10, 1'b1, 2, 0);
    expectPeriod("R3", 32, 1, 18);
    setCfg(2'b01, 1'b1, 1, 0);
    expectPeriod("R3", 16, 1, 9);
  endtask

  task automatic testStdClamp();
    setCfg(2'b00, 1'b0, 2, 0);
    expectPeriod("R4", 4, 1, 4);
    setCfg(2'b00, 1'b1, 0, 0);
    expectPeriod("R4", 4, 1, 4);
  endtask

  task automatic testFastClamp();
    setCfg(2'b01, 1'b0, 0, 0);
    expectPeriod("R5", 2, 1, 1);
  endtask

  task automatic testRise();
    setCfg(2'b00, 1'b0, 10, 3);
    expectPeriod("R6", 10, 1, 7);
    setCfg(2'b01, 1'b0, 2, 20);
    expectPeriod("R6", 4, 1, 1);
    setCfg(2'b00, 1'b0, 200, 127);
    expectPeriod("R6", 200, 1, 73);
  endtask

  task automatic testStretch();
    int l = 0, w = 0, h = 0, guard = 0;
    setCfg(2'b00, 1'b0, 5, 0);
    stretch = 1'b1;
    while (sclDriveLow && guard < 3000) begin
      l++; guard++;
      @(negedge clk);
    end
    while (!highStart && guard < 3000) begin
      w++; guard++;
      if (w == 5) stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
    do begin
      h++; guard++;
      @(negedge clk);
    end while (!lowStart && guard < 3000);
    check("R7", "stretched low ticks", l, 5);
    check("R7", "stretched wait ticks", w, 5);
    check("R7", "stretched high ticks", h, 5);
  endtask

  task automatic testMidChange();
    setCfg(2'b00, 1'b0, 5, 0);
    divCount = DIV_W'(8);
    expectPeriod("R9", 5, 1, 5);
    expectPeriod("R9", 8, 1, 8);
    setCfg(2'b00, 1'b0, 4, 0);
    modeSel  = 2'b01;
    dutySel  = 1'b1;
    divCount = DIV_W'(1);
    expectPeriod("R9", 4, 1, 4);
    expectPeriod("R9", 16, 1, 9);
  endtask

  task automatic testDisable();
    int seenStrobe = 0, seenDrive = 0;
    setCfg(2'b00, 1'b0, 6, 0);
    repeat (2) @(negedge clk);
    runEn = 1'b0;
    repeat (5) begin
      @(negedge clk);
      if (lowStart || highStart) seenStrobe++;
      if (sclDriveLow) seenDrive++;
    end
    check("R8", "drive while disabled", seenDrive, 0);
    check("R8", "strobes while disabled", seenStrobe, 0);
    runEn = 1'b1;
    @(negedge clk);
    check("R11", "lowStart on re-enable", int'(lowStart), 1);
    expectPeriod("R8", 6, 1, 6);
  endtask

  task automatic testTick();
    setCfg(2'b00, 1'b0, 4, 0);
    tickMode = 1'b1;
    syncLow();
    expectPeriod("R10", 8, 2, 8);
    tickMode = 1'b0;
    syncLow();
    expectPeriod("R10", 4, 1, 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testStandard();
    testFastTwo();
    testFastSixteen();
    testStdClamp();
    testFastClamp();
    testRise();
    testStretch();
    testMidChange();
    testDisable();
    testTick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule